// File: doc/BRIEF.md
# Dual-Edge Address Phase Receiver

This block receives the address phase of a transaction on a shared processor bus. The address lines and the request-code lines are active low. They are split over two lanes, and each lane has its own active-low source-synchronous strobe. A lane captures its lines twice:

- On the strobe's falling edge it captures the first sub-phase, which is the physical address and the first request code.
- On the strobe's rising edge it captures the second sub-phase, which is attribute (transaction-type) information carried on the same address lines, plus a second request code.

The lower lane carries the request code and address bits 16 to 3. The upper lane carries address bits 35 to 17, giving a 2^36-byte space on 8-byte granules.

A small controller runs in the bus clock domain. It watches the active-low transaction-start pin and waits until both lanes report that their second edge has passed. It then presents one decoded, active-high request for exactly one bus clock.

Three further functions complete the block:

- **Address wrap mask.** An asynchronous, active-low wrap-mask input is synchronised and, while asserted, clears address bit 20 of the presented request.
- **Stall protection.** A transaction start that coincides with the active-low stall pin is refused. The refusal raises a one-cycle protocol-error pulse, and the strobes belonging to it are swallowed.
- **Boot configuration.** On the first bus clock after reset is released, eight address lines are sampled and held as boot configuration.

Controller states:

- **IDLE**: waiting for a start. Stray lane completions are consumed here.
- **COLLECT**: an accepted start is waiting for both lanes.
- **ISSUE**: the one cycle in which the request is presented.
- **DISCARD**: a refused start is waiting for its lanes so that they can be dropped.

Controller transitions:

| From | To | Condition |
|---|---|---|
| IDLE | COLLECT | start seen with no stall |
| IDLE | DISCARD | start seen together with a stall |
| COLLECT | ISSUE | both lanes complete |
| ISSUE | IDLE | always, after one cycle |
| DISCARD | IDLE | both lanes complete |

Top module: `addr_phase_rx`

## Requirements
- R1: During the valid cycle, `rq_addr` equals the bitwise inverse of the `addr_n` pins held at the falling edge of the strobes. Bits 16..3 come from the lower lane and bits 35..17 from the upper lane.
- R2: During the valid cycle, `rq_attr` equals the inverse of `addr_n` at the rising edge of the strobes, and `rq_code2` equals the inverse of `req_n` at that rising edge.
- R3: During the valid cycle, `rq_code1` equals the inverse of `req_n` at the falling edge of the lower strobe.
- R4: Each accepted start (`start_n` low while `hold_n` high), followed by one falling and one rising edge on each strobe, produces `rq_valid` high for exactly one bus clock.
- R5: While `wrap_mask_n` is low (after synchronisation), bit 20 of `rq_addr` reads 0. While it is high, bit 20 follows the pins.
- R6: A start sampled while `hold_n` is low produces `rq_stall_err` high for exactly one clock and no `rq_valid`. The next accepted start is then presented normally.
- R7: `boot_cfg` holds the inverse of `addr_n[10:3]` as seen on the first clock after `rst_n` rises. Later pin activity does not change it.
- R8: While and just after reset, `rq_valid` and `rq_stall_err` are 0.
- R9: Strobe activity with no start produces no `rq_valid`. The following real transaction presents its own data, not the stray data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_n | input | 33 | Address lines [35:3], active low |
| req_n | input | 5 | Request-code lines, active low |
| strb_lo_n | input | 1 | Strobe for `req_n` and `addr_n[16:3]`, active low |
| strb_hi_n | input | 1 | Strobe for `addr_n[35:17]`, active low |
| start_n | input | 1 | Transaction start, active low, sampled on `clk` |
| hold_n | input | 1 | Bus stall, active low, sampled on `clk` |
| wrap_mask_n | input | 1 | Asynchronous address-bit-20 mask, active low |
| rq_valid | output | 1 | One-cycle request-present pulse |
| rq_addr | output | 33 | Decoded address [35:3] |
| rq_attr | output | 33 | Second sub-phase attribute field [35:3] |
| rq_code1 | output | 5 | First sub-phase request code |
| rq_code2 | output | 5 | Second sub-phase request code |
| rq_stall_err | output | 1 | One-cycle pulse on a start refused for a stall |
| boot_cfg | output | 8 | Boot configuration taken at reset release |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:

- **Mixed-up edges.** It uses patterns where the first and second sub-phases differ in every bit. A design that swapped the edges, or took the second sub-phase for both, would show the wrong field on `rq_attr` or `rq_code1`.
- **Lane split.** Patterns sit on each side of bit 17, so a lane slice off by one bit cannot pass.
- **Wrap mask.** It applies the mask to an address whose only set bit is bit 20, and leaves it off for an address with bit 20 set. A mask on the wrong bit or of the wrong polarity therefore fails one case or the other.
- **Stall refusal.** A design that forwarded a refused start would pulse `rq_valid`. One that did not swallow the refused strobes would present stale data on the next request.
- **Boot capture.** It changes the pins after reset. A strap register that kept sampling would drift.

// File: rtl/addr_phase_pkg.sv
`timescale 1ns/1ps
package addr_phase_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_ISSUE   = 2'd2,
        ST_DISCARD = 2'd3
    } rx_state_e;

endpackage

// File: rtl/aprx_sync.sv
`timescale 1ns/1ps
module aprx_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/aprx_lane.sv
`timescale 1ns/1ps
module aprx_lane #(
    parameter int W = 19
) (
    input  logic         stb_n,
    input  logic         rst_n,
    input  logic [W-1:0] pins_n,
    output logic [W-1:0] first,
    output logic [W-1:0] second,
    output logic         done_tog
);
    // Assertion edge of the strobe: first sub-phase.
    always_ff @(negedge stb_n or negedge rst_n) begin
        if (!rst_n) begin
            first <= '0;
        end else begin
            first <= ~pins_n;
        end
    end

    // Release edge of the strobe: second sub-phase, then mark completion.
    always_ff @(posedge stb_n or negedge rst_n) begin
        if (!rst_n) begin
            second   <= '0;
            done_tog <= 1'b0;
        end else begin
            second   <= ~pins_n;
            done_tog <= ~done_tog;
        end
    end
endmodule

// File: rtl/aprx_ctrl.sv
`timescale 1ns/1ps
module aprx_ctrl
    import addr_phase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stall,
    input  logic [1:0] lane_tog,
    output logic       take,
    output logic       valid,
    output logic       reject
);
    rx_state_e  state_q;
    rx_state_e  state_d;
    logic [1:0] ack_q;
    logic       both_done;
    logic       consume;

    assign both_done = &(lane_tog ^ ack_q);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Completion bookkeeping for the two lanes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= '0;
        end else if (consume) begin
            ack_q <= lane_tog;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = stall ? ST_DISCARD : ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (both_done) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                state_d = ST_IDLE;
            end
            ST_DISCARD: begin
                if (both_done) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Outputs.
    always_comb begin
        take    = 1'b0;
        valid   = 1'b0;
        reject  = 1'b0;
        consume = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                consume = 1'b1;
                reject  = start && stall;
            end
            ST_COLLECT: begin
                take    = both_done;
                consume = both_done;
            end
            ST_ISSUE: begin
                valid = 1'b1;
            end
            ST_DISCARD: begin
                consume = both_done;
            end
        endcase
    end
endmodule

// File: rtl/addr_phase_rx.sv
`timescale 1ns/1ps
module addr_phase_rx #(
    parameter int ADDR_HI   = 35,
    parameter int ADDR_LO   = 3,
    parameter int SPLIT_BIT = 17,
    parameter int REQ_W     = 5,
    parameter int WRAP_BIT  = 20,
    parameter int STRAP_LSB = 3,
    parameter int STRAP_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_HI:ADDR_LO] addr_n,
    input  logic [REQ_W-1:0]       req_n,
    input  logic                   strb_lo_n,
    input  logic                   strb_hi_n,
    input  logic                   start_n,
    input  logic                   hold_n,
    input  logic                   wrap_mask_n,
    output logic                   rq_valid,
    output logic [ADDR_HI:ADDR_LO] rq_addr,
    output logic [ADDR_HI:ADDR_LO] rq_attr,
    output logic [REQ_W-1:0]       rq_code1,
    output logic [REQ_W-1:0]       rq_code2,
    output logic                   rq_stall_err,
    output logic [STRAP_W-1:0]     boot_cfg
);
    localparam int LO_W = SPLIT_BIT - ADDR_LO;
    localparam int HI_W = ADDR_HI - SPLIT_BIT + 1;
    localparam int L0_W = REQ_W + LO_W;

    logic [L0_W-1:0] lo_first, lo_second;
    logic [HI_W-1:0] hi_first, hi_second;
    logic [1:0]      tog_raw, tog_s;
    logic            wrap_on;
    logic            take, valid, reject;
    logic            rst_seen_q;
    logic            err_q;

    logic [ADDR_HI:ADDR_LO] addr_m;
    logic [ADDR_HI:ADDR_LO] addr_q, attr_q;
    logic [REQ_W-1:0]       code1_q, code2_q;
    logic [STRAP_W-1:0]     strap_q;

    aprx_lane #(.W(L0_W)) u_lane_lo (
        .stb_n    (strb_lo_n),
        .rst_n    (rst_n),
        .pins_n   ({req_n, addr_n[SPLIT_BIT-1:ADDR_LO]}),
        .first    (lo_first),
        .second   (lo_second),
        .done_tog (tog_raw[0])
    );

    aprx_lane #(.W(HI_W)) u_lane_hi (
        .stb_n    (strb_hi_n),
        .rst_n    (rst_n),
        .pins_n   (addr_n[ADDR_HI:SPLIT_BIT]),
        .first    (hi_first),
        .second   (hi_second),
        .done_tog (tog_raw[1])
    );

    aprx_sync #(.W(2)) u_sync_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tog_raw),
        .q     (tog_s)
    );

    aprx_sync #(.W(1)) u_sync_wrap (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (~wrap_mask_n),
        .q     (wrap_on)
    );

    aprx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (~start_n),
        .stall    (~hold_n),
        .lane_tog (tog_s),
        .take     (take),
        .valid    (valid),
        .reject   (reject)
    );

    // Merge the first sub-phase of both lanes and apply the wrap mask.
    always_comb begin
        addr_m           = {hi_first, lo_first[LO_W-1:0]};
        addr_m[WRAP_BIT] = addr_m[WRAP_BIT] & ~wrap_on;
    end

    // Request holding register, loaded on the collect-to-issue transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            attr_q  <= '0;
            code1_q <= '0;
            code2_q <= '0;
        end else if (take) begin
            addr_q  <= addr_m;
            attr_q  <= {hi_second, lo_second[LO_W-1:0]};
            code1_q <= lo_first[L0_W-1:LO_W];
            code2_q <= lo_second[L0_W-1:LO_W];
        end
    end

    // Refused start: one-cycle error pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= reject;
        end
    end

    // Boot configuration taken on the first clock after reset release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_seen_q <= 1'b0;
            strap_q    <= '0;
        end else begin
            rst_seen_q <= 1'b1;
            if (!rst_seen_q) begin
                strap_q <= ~addr_n[STRAP_LSB +: STRAP_W];
            end
        end
    end

    assign rq_valid     = valid;
    assign rq_addr      = addr_q;
    assign rq_attr      = attr_q;
    assign rq_code1     = code1_q;
    assign rq_code2     = code2_q;
    assign rq_stall_err = err_q;
    assign boot_cfg     = strap_q;
endmodule

// File: rtl/addr_phase_rx_checker.sv
`timescale 1ns/1ps
module addr_phase_rx_checker #(
    parameter int STRAP_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_n,
    input logic               hold_n,
    input logic               rq_valid,
    input logic               rq_stall_err,
    input logic               wrap_bit,
    input logic               wrap_on,
    input logic               boot_done,
    input logic [STRAP_W-1:0] boot_cfg
);
    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |=> !rq_valid);

    assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rq_stall_err |=> !rq_stall_err);

    assert_err_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_valid && rq_stall_err));

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rq_stall_err |-> $past(!start_n && !hold_n));

    assert_wrap_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && $past(wrap_on)) |-> !wrap_bit);

    assert_boot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> $stable(boot_cfg));
endmodule

bind addr_phase_rx addr_phase_rx_checker #(.STRAP_W(STRAP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_n      (start_n),
    .hold_n       (hold_n),
    .rq_valid     (rq_valid),
    .rq_stall_err (rq_stall_err),
    .wrap_bit     (rq_addr[WRAP_BIT]),
    .wrap_on      (wrap_on),
    .boot_done    (rst_seen_q),
    .boot_cfg     (boot_cfg)
);

// File: tb/addr_phase_rx_test.sv
`timescale 1ns/1ps
module addr_phase_rx_test;

    typedef struct packed {
        logic [32:0] a1;
        logic [4:0]  r1;
        logic [32:0] a2;
        logic [4:0]  r2;
        logic        wrap;
        logic        stall;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        {33'h0_1234_5678, 5'h03, 33'h1_0000_00F0, 5'h1C, 1'b0, 1'b0},
        {33'h1_FFFF_FFFF, 5'h1F, 33'h0_0000_0000, 5'h00, 1'b0, 1'b0},
        {33'h1_FFFF_FFFF, 5'h0A, 33'h0_5555_5555, 5'h15, 1'b1, 1'b0},
        {33'h0_0002_0000, 5'h11, 33'h1_AAAA_AAAA, 5'h02, 1'b1, 1'b0},
        {33'h0_0BAD_F00D, 5'h07, 33'h0_0000_0001, 5'h01, 1'b0, 1'b1},
        {33'h0_0002_0001, 5'h05, 33'h0_CAFE_0000, 5'h1E, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [32:0] addr_n = '1;
    logic [4:0]  req_n = '1;
    logic        strb_lo_n = 1'b1;
    logic        strb_hi_n = 1'b1;
    logic        start_n = 1'b1;
    logic        hold_n = 1'b1;
    logic        wrap_mask_n = 1'b1;
    logic        rq_valid;
    logic [32:0] rq_addr;
    logic [32:0] rq_attr;
    logic [4:0]  rq_code1;
    logic [4:0]  rq_code2;
    logic        rq_stall_err;
    logic [7:0]  boot_cfg;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valid, n_err;
    logic [32:0] got_addr, got_attr;
    logic [4:0]  got_c1, got_c2;

    always #10 clk = ~clk;

    addr_phase_rx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_n       (addr_n),
        .req_n        (req_n),
        .strb_lo_n    (strb_lo_n),
        .strb_hi_n    (strb_hi_n),
        .start_n      (start_n),
        .hold_n       (hold_n),
        .wrap_mask_n  (wrap_mask_n),
        .rq_valid     (rq_valid),
        .rq_addr      (rq_addr),
        .rq_attr      (rq_attr),
        .rq_code1     (rq_code1),
        .rq_code2     (rq_code2),
        .rq_stall_err (rq_stall_err),
        .boot_cfg     (boot_cfg)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sample_outs();
        if (rq_valid) begin
            n_valid++;
            got_addr = rq_addr;
            got_attr = rq_attr;
            got_c1   = rq_code1;
            got_c2   = rq_code2;
        end
        if (rq_stall_err) n_err++;
    endtask

    // Both strobes: fall with sub-phase one on the pins, rise with sub-phase two.
    task automatic drive_strobes(input logic [32:0] a1, input logic [4:0] r1,
                                 input logic [32:0] a2, input logic [4:0] r2);
        addr_n = ~a1;
        req_n  = ~r1;
        #2;
        strb_lo_n = 1'b0;
        strb_hi_n = 1'b0;
        #3;
        addr_n = ~a2;
        req_n  = ~r2;
        #2;
        strb_lo_n = 1'b1;
        strb_hi_n = 1'b1;
        #2;
        addr_n = '1;
        req_n  = '1;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [32:0] exp_addr;
        wrap_mask_n = ~v.wrap;
        repeat (4) @(negedge clk);
        n_valid = 0;
        n_err   = 0;
        start_n = 1'b0;
        hold_n  = ~v.stall;
        @(negedge clk);
        sample_outs();
        start_n = 1'b1;
        hold_n  = 1'b1;
        drive_strobes(v.a1, v.r1, v.a2, v.r2);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            sample_outs();
        end
        exp_addr = v.a1;
        if (v.wrap) exp_addr[17] = 1'b0;
        if (v.stall) begin
            check(n_valid == 0, $sformatf("R6 vec%0d no valid", idx), 64'(n_valid), 64'd0);
            check(n_err == 1, $sformatf("R6 vec%0d err pulse", idx), 64'(n_err), 64'd1);
        end else begin
            check(n_valid == 1, $sformatf("R4 vec%0d valid count", idx), 64'(n_valid), 64'd1);
            check(n_err == 0, $sformatf("R6 vec%0d no err", idx), 64'(n_err), 64'd0);
            check(got_addr == exp_addr, $sformatf("R1/R5 vec%0d addr", idx), 64'(got_addr), 64'(exp_addr));
            check(got_c1 == v.r1, $sformatf("R3 vec%0d code1", idx), 64'(got_c1), 64'(v.r1));
            check(got_attr == v.a2, $sformatf("R2 vec%0d attr", idx), 64'(got_attr), 64'(v.a2));
            check(got_c2 == v.r2, $sformatf("R2 vec%0d code2", idx), 64'(got_c2), 64'(v.r2));
        end
    endtask

    initial begin
        addr_n = ~{25'h0, 8'hA5};
        repeat (3) @(negedge clk);
        // R8: outputs quiet during reset.
        check(rq_valid == 1'b0, "R8 valid in reset", 64'(rq_valid), 64'd0);
        check(rq_stall_err == 1'b0, "R8 err in reset", 64'(rq_stall_err), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rq_valid == 1'b0, "R8 valid after reset", 64'(rq_valid), 64'd0);
        check(boot_cfg == 8'hA5, "R7 boot capture", 64'(boot_cfg), 64'hA5);
        addr_n = ~{25'h0, 8'h3C};
        repeat (3) @(negedge clk);
        check(boot_cfg == 8'hA5, "R7 boot held", 64'(boot_cfg), 64'hA5);
        addr_n = '1;

        // R9: strobes without a start are ignored.
        n_valid = 0;
        @(negedge clk);
        drive_strobes(33'h1_DEAD_BEEF, 5'h0F, 33'h0_1111_1111, 5'h12);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            sample_outs();
        end
        check(n_valid == 0, "R9 no valid without start", 64'(n_valid), 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], i);
        end

        // R9: a second stray burst, then a real transaction must carry fresh data.
        drive_strobes(33'h0_7777_7777, 5'h19, 33'h0_3333_3333, 5'h06);
        repeat (6) @(negedge clk);
        run_vec({33'h0_0000_0008, 5'h04, 33'h1_0000_0001, 5'h08, 1'b0, 1'b0}, 99);
        check(got_addr == 33'h0_0000_0008, "R9 fresh addr after stray", 64'(got_addr), 64'h8);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule